// File: doc/BRIEF.md
# Cut-Through Receive Frame Writer

The block accepts a receive stream four bits at a time. Each beat is a data-valid flag plus a nibble, already in the system clock domain. It waits for the start-of-frame delimiter and then writes the frame body to a host-side ring buffer while the frame is still arriving. There is no whole-frame staging. The path stays four bits wide all the way through. Nibbles are gathered into 32-bit words only at the buffer write port.

A streaming CRC-32 runs over the body and the trailing frame check sequence together. A byte counter runs alongside it. When data-valid drops, the block flushes any partly filled word and then judges the frame.

- A good frame moves the committed pointer past its last word and reports its byte count.
- A bad frame moves the write pointer back to the committed pointer and pulses an error flag. The next frame then overwrites the discarded data.

The host reads only up to the committed pointer.

Top module: `rx_cut_through_writer`

## Requirements
- R1: Nibbles that arrive before the first nibble equal to 4'hD are delimiter/preamble and are never written. A burst of data-valid that ends without a 4'hD nibble produces no write, no status and no error.
- R2: Body nibble k of each group of eight goes to wr_data bits [4k+3:4k], so the first nibble of a byte is its low half and the first byte of a word is bits [7:0]. Each full word is written one cycle after its eighth nibble is sampled, at consecutive addresses starting at the committed pointer.
- R3: When data-valid falls with a partly filled word, that word is written with zeros in its unfilled upper bits, one cycle after the low data-valid is sampled.
- R4: The CRC register starts at all ones and steps only on body nibbles, least-significant bit first, with the reflected polynomial 32'hEDB88320. The frame passes the CRC test when the bit-reversed register equals 32'hC704DD7B after the last nibble, FCS included. The register returns to all ones after every check.
- R5: The frame passes the length test only when its byte count, FCS included, lies within 64 to 1518 inclusive.
- R6: A frame passing both tests raises stat_valid for one cycle, in the cycle after the low data-valid is sampled. stat_bytes holds the byte count, and commit_ptr advances past the frame's last written word. commit_ptr never changes at any other time.
- R7: A frame failing either test raises frame_err for one cycle and leaves commit_ptr unchanged. The next frame's first word is written at commit_ptr.
- R8: A frame that follows a failed frame is judged on its own data only.
- R9: Reset clears commit_ptr to 0 and holds wr_en, stat_valid and frame_err low.
- R10: stat_valid and frame_err are never high together, and neither is high in a cycle whose previous sampled data-valid was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid |
| rx_d | input | 4 | Receive nibble |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer word address |
| wr_data | output | 32 | Packed buffer word |
| commit_ptr | output | AW | Word address one past the last accepted frame |
| stat_valid | output | 1 | One-cycle pulse for an accepted frame |
| stat_bytes | output | 12 | Byte count of the accepted frame, FCS included |
| frame_err | output | 1 | One-cycle pulse for a discarded frame |

## Verification
The bench targets the length edges on both sides: 63, 64, 1518 and 1519 bytes. A design with an off-by-one comparison accepts a runt or an oversized frame, or drops a legal one.

A frame of 65 bytes ends mid-word. This exposes a missing flush, which leaves a word count short, and non-zero padding, which shows up as wrong upper bytes.

A frame with a single flipped FCS bit is followed by a good frame. A design that fails to rewind writes the good frame at the wrong address. A design that fails to reload the CRC rejects the good frame.

A preamble burst with no delimiter must leave every output quiet.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int          NIB_W       = 4;
    localparam int          WORD_W      = 32;
    localparam int          NIBS_PER_WD = WORD_W / NIB_W;
    localparam logic [3:0]  SFD_NIB     = 4'hD;
    localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_PRE,
        RX_BODY
    } rx_state_e;

    typedef struct packed {
        logic             vld;
        logic [NIB_W-1:0] nib;
    } nib_beat_t;

    // Advance a reflected CRC-32 register by one nibble, LSB first.
    function automatic logic [31:0] crc_step_nib(input logic [31:0] c, input logic [3:0] n);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 4; i++) begin
            fb = r[0] ^ n[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY_R;
        end
        return r;
    endfunction

    function automatic logic [31:0] bitrev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

endpackage

// File: rtl/rxw_crc.sv
module rxw_crc
    import rxw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  nib_beat_t beat,
    input  logic      reload,
    output logic      residue_ok
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || reload) crc_q <= CRC_PRESET;
        else if (beat.vld) crc_q <= crc_step_nib(crc_q, beat.nib);
    end

    assign residue_ok = (bitrev32(crc_q) == CRC_RESIDUE);
endmodule

// File: rtl/rxw_lencount.sv
module rxw_lencount
    import rxw_pkg::*;
#(
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518,
    parameter int NW        = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  nib_beat_t     beat,
    input  logic          clear,
    output logic [NW-2:0] bytes,
    output logic          len_ok
);
    localparam int          LW    = NW - 1;
    localparam logic [LW-1:0] MIN_L = LW'(MIN_BYTES);
    localparam logic [LW-1:0] MAX_L = LW'(MAX_BYTES);

    logic [NW-1:0] nib_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) nib_cnt <= '0;
        else if (beat.vld && nib_cnt != '1) nib_cnt <= nib_cnt + 1'b1;
    end

    assign bytes  = nib_cnt[NW-1:1];
    assign len_ok = (bytes >= MIN_L) && (bytes <= MAX_L);
endmodule

// File: rtl/rxw_packer.sv
module rxw_packer
    import rxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  nib_beat_t         beat,
    input  logic              flush,
    output logic              emit,
    output logic [WORD_W-1:0] word
);
    localparam int          CW   = $clog2(NIBS_PER_WD);
    localparam logic [CW-1:0] LAST = CW'(NIBS_PER_WD - 1);

    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic [WORD_W-1:0] placed;

    assign placed = sh_q | (WORD_W'(beat.nib) << (NIB_W * cnt_q));
    assign emit   = (beat.vld && cnt_q == LAST) || (flush && cnt_q != '0);
    assign word   = beat.vld ? placed : sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (beat.vld) begin
            if (cnt_q == LAST) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else begin
                sh_q  <= placed;
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (flush) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/rx_cut_through_writer.sv
module rx_cut_through_writer
    import rxw_pkg::*;
#(
    parameter int AW        = 10,
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518,
    parameter int NW        = $clog2(2 * MAX_BYTES + 1) + 1,
    parameter int LW        = NW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_dv,
    input  logic [3:0]        rx_d,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [AW-1:0]     commit_ptr,
    output logic              stat_valid,
    output logic [LW-1:0]     stat_bytes,
    output logic              frame_err
);
    rx_state_e         state_q, state_d;
    nib_beat_t         beat;
    logic              frame_end;
    logic              crc_ok, len_ok, emit;
    logic [WORD_W-1:0] word;
    logic [LW-1:0]     bytes;
    logic [AW-1:0]     wr_ptr_q, ptr_adv;

    assign beat.vld  = (state_q == RX_BODY) && rx_dv;
    assign beat.nib  = rx_d;
    assign frame_end = (state_q == RX_BODY) && !rx_dv;
    assign ptr_adv   = wr_ptr_q + AW'(emit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rx_dv) state_d = (rx_d == SFD_NIB) ? RX_BODY : RX_PRE;
            RX_PRE:  if (!rx_dv) state_d = RX_IDLE;
                     else if (rx_d == SFD_NIB) state_d = RX_BODY;
            RX_BODY: if (!rx_dv) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    rxw_crc u_crc (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .reload     (frame_end),
        .residue_ok (crc_ok)
    );

    rxw_lencount #(.MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .NW(NW)) u_len (
        .clk    (clk),
        .rst    (rst),
        .beat   (beat),
        .clear  (frame_end),
        .bytes  (bytes),
        .len_ok (len_ok)
    );

    rxw_packer u_pack (
        .clk   (clk),
        .rst   (rst),
        .beat  (beat),
        .flush (frame_end),
        .emit  (emit),
        .word  (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_IDLE;
            wr_ptr_q   <= '0;
            commit_ptr <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            stat_valid <= 1'b0;
            stat_bytes <= '0;
            frame_err  <= 1'b0;
        end else begin
            state_q    <= state_d;
            wr_en      <= emit;
            stat_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (emit) begin
                wr_addr <= wr_ptr_q;
                wr_data <= word;
            end
            if (frame_end) begin
                if (crc_ok && len_ok) begin
                    wr_ptr_q   <= ptr_adv;
                    commit_ptr <= ptr_adv;
                    stat_valid <= 1'b1;
                    stat_bytes <= bytes;
                end else begin
                    wr_ptr_q  <= commit_ptr;
                    frame_err <= 1'b1;
                end
            end else if (emit) begin
                wr_ptr_q <= ptr_adv;
            end
        end
    end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int AW        = 10,
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518,
    parameter int LW        = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_dv,
    input logic [AW-1:0] commit_ptr,
    input logic          stat_valid,
    input logic [LW-1:0] stat_bytes,
    input logic          frame_err
);
    // R10
    excl_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat_valid && frame_err));

    // R10
    result_after_dv_low_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid || frame_err) |-> !$past(rx_dv));

    // R7
    hold_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $stable(commit_ptr));

    // R6
    commit_only_good_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_valid |-> $stable(commit_ptr));

    // R5
    len_window_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_bytes >= LW'(MIN_BYTES) && stat_bytes <= LW'(MAX_BYTES)));
endmodule

bind rx_cut_through_writer rxw_checker #(
    .AW(AW), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .LW(LW)
) i_rxw_checker (
    .clk        (clk),
    .rst        (rst),
    .rx_dv      (rx_dv),
    .commit_ptr (commit_ptr),
    .stat_valid (stat_valid),
    .stat_bytes (stat_bytes),
    .frame_err  (frame_err)
);

// File: tb/test_rx_cut_through_writer.sv
`timescale 1ns/1ps
module test_rx_cut_through_writer;
    localparam int AW    = 10;
    localparam int MIN_B = 64;
    localparam int MAX_B = 1518;
    localparam int LW    = $clog2(2 * MAX_B + 1);
    localparam int NV    = 7;

    // payload bytes (FCS added), corrupt FCS, expected accept
    localparam int V_PAY  [NV] = '{60, 59, 1514, 1515, 100, 61, 60};
    localparam bit V_BAD  [NV] = '{0, 0, 0, 0, 1, 0, 0};
    localparam bit V_GOOD [NV] = '{1, 0, 1, 0, 0, 1, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_dv = 1'b0;
    logic [3:0]    rx_d = 4'h0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic [AW-1:0] commit_ptr;
    logic          stat_valid;
    logic [LW-1:0] stat_bytes;
    logic          frame_err;

    always #2 clk = ~clk;

    rx_cut_through_writer #(.AW(AW), .MIN_BYTES(MIN_B), .MAX_BYTES(MAX_B)) i_rx_cut_through_writer (
        .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_d(rx_d),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_ptr(commit_ptr), .stat_valid(stat_valid),
        .stat_bytes(stat_bytes), .frame_err(frame_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]    fb [0:2047];
    int            flen;
    logic [AW-1:0] base;
    logic [AW-1:0] model_commit = '0;
    int            widx;
    int            got_stat, got_err;
    logic [LW-1:0] got_bytes;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (4 * w + k < flen) r[8*k +: 8] = fb[4 * w + k];
        return r;
    endfunction

    function automatic logic [31:0] crc_bytes(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic f;
                f = c[0] ^ fb[i][b];
                c = c >> 1;
                if (f) c = c ^ 32'hEDB8_8320;
            end
        return c;
    endfunction

    task automatic build(input int pay, input bit bad);
        logic [31:0] fcs;
        for (int i = 0; i < pay; i++) fb[i] = 8'(i * 13 + pay);
        fcs = ~crc_bytes(pay);
        for (int k = 0; k < 4; k++) fb[pay + k] = fcs[8*k +: 8];
        if (bad) fb[pay] = fb[pay] ^ 8'h01;
        flen = pay + 4;
    endtask

    task automatic drive(input bit with_sfd, input int nbytes);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk); rx_dv = 1'b1; rx_d = 4'h5;
        end
        if (with_sfd) begin
            @(negedge clk); rx_d = 4'hD;
            for (int i = 0; i < nbytes; i++) begin
                @(negedge clk); rx_d = fb[i][3:0];
                @(negedge clk); rx_d = fb[i][7:4];
            end
        end
        @(negedge clk); rx_dv = 1'b0; rx_d = 4'h0;
        repeat (10) @(negedge clk);
    endtask

    task automatic arm();
        base = model_commit; widx = 0; got_stat = 0; got_err = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                chk(wr_addr == base + AW'(widx), "R2/R7 word address", 64'(wr_addr), 64'(base + AW'(widx)));
                chk(wr_data == exp_word(widx), "R2/R3 word data", 64'(wr_data), 64'(exp_word(widx)));
                widx++;
            end
            if (stat_valid) begin got_stat++; got_bytes = stat_bytes; end
            if (frame_err) got_err++;
        end
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(commit_ptr == '0, "R9 commit_ptr", 64'(commit_ptr), 0);
        chk(!wr_en && !stat_valid && !frame_err, "R9 quiet outputs",
            64'({wr_en, stat_valid, frame_err}), 0);

        // R4 R5 R6 R7 R8: vector walk (entry 5 follows the bad-FCS frame)
        for (int v = 0; v < NV; v++) begin
            int nw;
            build(V_PAY[v], V_BAD[v]);
            arm();
            drive(1'b1, flen);
            nw = (2 * flen + 7) / 8;
            chk(widx == nw, "R3 words written", 64'(widx), 64'(nw));
            if (V_GOOD[v]) begin
                chk(got_stat == 1 && got_err == 0, "R4/R5 accept verdict",
                    64'({got_stat, got_err}), 64'h1_0000_0000);
                chk(got_bytes == LW'(flen), "R6 byte count", 64'(got_bytes), 64'(flen));
                model_commit = base + AW'(nw);
            end else begin
                chk(got_err == 1 && got_stat == 0, "R4/R5 reject verdict R7",
                    64'({got_stat, got_err}), 64'h1);
            end
            chk(commit_ptr == model_commit, "R6/R7 commit pointer", 64'(commit_ptr), 64'(model_commit));
        end

        // R1 preamble burst with no delimiter
        arm();
        drive(1'b0, 0);
        chk(widx == 0 && got_stat == 0 && got_err == 0, "R1 no action without delimiter",
            64'(widx + got_stat + got_err), 0);
        chk(commit_ptr == model_commit, "R1 commit pointer", 64'(commit_ptr), 64'(model_commit));

        // R8 minimum frame still accepted after the abort
        build(60, 1'b0);
        arm();
        drive(1'b1, flen);
        chk(got_stat == 1 && got_err == 0, "R8 clean verdict", 64'({got_stat, got_err}), 64'h1_0000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule